// File: doc/BRIEF.md
# Serial TDM Timeslot Port Controller

This block runs one serial time-division port that carries four 8-bit timeslots per frame. Data leaves on a single output bit together with an active-high drive enable, and it arrives on a single input bit. Both move most significant bit first, one bit per clock. Timeslot 0 carries a two-bit signalling channel. Timeslot 1 carries a control/status byte that lives in a register. Timeslots 2 and 3 carry voice PCM. A frame-start pulse aligns the bit and slot position. Between pulses the position free-runs and wraps around.

A small register port sets the enables. For each transmit slot, the enables decide whether the slot drives data, drives zeros or is left undriven. They also decide which voice slot feeds the receive PCM output. Two loopback modes are provided. The first sends the input pin straight to the output pin. The second feeds the locally generated stream into the receive path.

Top module: `tdm_port_ctrl`

## Requirements
- R1: Bits go MSB first, one per clock. The cycle in which `frame_start_i` is high is slot 0, bit 7. After it the position counts down through the bits and up through the slots, and slot 3 bit 0 is followed by slot 0 bit 7 without a pulse.
- R2: In slot 0, bits 7..2 are never driven (`tx_oe_o`=0). Bits 1..0 are always driven: they carry `sig_tx_i[1:0]` when enable bit 0 is set, and 0 when it is clear.
- R3: Slot 1 drives the control/status register byte when enable bit 1 is set, and is undriven when that bit is clear.
- R4: Slots 2 and 3 are always driven. PCM goes out in slot 2 if enable bit 2 is set. Otherwise it goes out in slot 3 if enable bit 3 is set. Any voice slot that does not carry PCM sends zeros. `pcm_tx_i` and `sig_tx_i` are sampled in the first bit cycle of their slot.
- R5: Receive PCM comes from slot 2 if enable bit 4 is set, otherwise from slot 3 if enable bit 5 is set. The byte appears on `pcm_rx_o` with a one-cycle `pcm_rx_valid_o` in the cycle after the slot's last bit. If neither bit is set, there is no strobe.
- R6: In every frame, the cycle after slot 0 ends, `sig_rx_o` takes bits 1..0 of the received slot-0 byte and `sig_rx_valid_o` pulses for one cycle.
- R7: At the end of slot 1, the received byte is always written into the control/status register, whatever the enables are. This capture wins over a register write made in the same cycle.
- R8: With loopback bit 0 (input-to-output) set, `tx_bit_o` equals `rx_bit_i`. `tx_oe_o` is then high only where the slot's own transmit enable is set (enable bits 0, 1, 2, 3 for slots 0, 1, 2, 3), and in slot 0 only on bits 1..0.
- R9: With loopback bit 1 (output-to-input) set, the receive path takes the generated transmit stream in place of `rx_bit_i`, with undriven positions read as 0. The pin outputs are unchanged by this bit.
- R10: Register address 0 is the control/status byte, 1 holds the enables, 2 holds the loopbacks, and 3 reads 0. Enable bits 7..6 and loopback bits 7..2 ignore writes and read 0.
- R11: Reset clears all registers and both valid strobes. During reset the position is slot 0, bit 7, so the output is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Marks slot 0 bit 7 in the current cycle |
| rx_bit_i | input | 1 | Serial input pin |
| tx_bit_o | output | 1 | Serial output data |
| tx_oe_o | output | 1 | Output drive enable, active high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| sig_tx_i | input | 2 | Outgoing signalling bits |
| sig_rx_o | output | 2 | Received signalling bits |
| sig_rx_valid_o | output | 1 | Signalling receive strobe |
| pcm_tx_i | input | 8 | Outgoing PCM sample |
| pcm_rx_o | output | 8 | Received PCM sample |
| pcm_rx_valid_o | output | 1 | PCM receive strobe |

## Verification
A position counter that is off by even one step moves the drive-enable pattern at once: undriven bits appear inside voice slots, or driven bits appear in the upper part of slot 0. That error shows up within the same frame, on a bit-by-bit compare. A wrong slot selection or a wrong held byte corrupts the serial data within one slot. A receive error shows up on the strobes or on the register readback at the latest one cycle after the frame ends. The sweep covers every enable and loopback combination, so a swapped priority or a loopback tapped from the wrong point fails on specific configurations and not on average ones.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOT_BITS = 8;
  localparam int NUM_SLOTS = 4;
  localparam int BIT_W     = $clog2(SLOT_BITS);
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int SIG_BITS  = 2;
  localparam int REG_AW    = 2;
  localparam int EN_W      = 6;
  localparam int LB_W      = 2;

  localparam logic [REG_AW-1:0] ADDR_CTL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_EN  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_LB  = 2'd2;

  // enable register bit positions
  localparam int EN_SIG_TX  = 0;
  localparam int EN_CTL_TX  = 1;
  localparam int EN_PCMA_TX = 2;
  localparam int EN_PCMB_TX = 3;
  localparam int EN_PCMA_RX = 4;
  localparam int EN_PCMB_RX = 5;
  // loopback register bit positions
  localparam int LB_IN2OUT  = 0;
  localparam int LB_OUT2IN  = 1;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_SIG   = 2'd0,
    SLOT_CTL   = 2'd1,
    SLOT_PCM_A = 2'd2,
    SLOT_PCM_B = 2'd3
  } slot_e;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter
  import tdm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  output slot_e            slot_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(SLOT_BITS - 1);

  slot_e            slot_q, slot_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_comb begin
    slot_o  = frame_start_i ? SLOT_SIG : slot_q;
    bit_o   = frame_start_i ? TOP_BIT : bit_q;
    first_o = (bit_o == TOP_BIT);
    last_o  = (bit_o == '0);
    if (last_o) begin
      bit_d  = TOP_BIT;
      slot_d = slot_e'(slot_o + 1'b1);
    end else begin
      bit_d  = bit_o - 1'b1;
      slot_d = slot_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= SLOT_SIG;
      bit_q  <= TOP_BIT;
    end else begin
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

  // R1
  frame_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (slot_q == SLOT_SIG && bit_q == TOP_BIT - 1'b1));

  // R1
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && slot_q == SLOT_PCM_B && bit_q == '0) |=> (slot_q == SLOT_SIG && bit_q == TOP_BIT));
endmodule

// File: rtl/tdm_regfile.sv
module tdm_regfile
  import tdm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [SLOT_BITS-1:0] wdata_i,
  output logic [SLOT_BITS-1:0] rdata_o,
  input  logic                 ctl_cap_i,
  input  logic [SLOT_BITS-1:0] ctl_cap_data_i,
  output logic [SLOT_BITS-1:0] ctl_o,
  output logic [EN_W-1:0]      en_o,
  output logic [LB_W-1:0]      lb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
      en_o  <= '0;
      lb_o  <= '0;
    end else begin
      // received slot-1 byte takes priority over software
      if (ctl_cap_i)                        ctl_o <= ctl_cap_data_i;
      else if (we_i && addr_i == ADDR_CTL)  ctl_o <= wdata_i;
      if (we_i && addr_i == ADDR_EN)        en_o  <= wdata_i[EN_W-1:0];
      if (we_i && addr_i == ADDR_LB)        lb_o  <= wdata_i[LB_W-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTL: rdata_o = ctl_o;
      ADDR_EN:  rdata_o = SLOT_BITS'(en_o);
      ADDR_LB:  rdata_o = SLOT_BITS'(lb_o);
      default:  rdata_o = '0;
    endcase
  end

  // R7
  ctl_cap_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_cap_i |=> (ctl_o == $past(ctl_cap_data_i)));

  // R10
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_EN) |=> (en_o == $past(wdata_i[EN_W-1:0])));
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
  import tdm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  slot_e                slot_i,
  input  logic [BIT_W-1:0]     bit_i,
  input  logic                 first_i,
  input  logic                 sig_tx_en_i,
  input  logic                 ctl_tx_en_i,
  input  logic                 pcm_a_tx_en_i,
  input  logic                 pcm_b_tx_en_i,
  input  logic                 in2out_i,
  input  logic [SLOT_BITS-1:0] ctl_i,
  input  logic [SIG_BITS-1:0]  sig_tx_i,
  input  logic [SLOT_BITS-1:0] pcm_tx_i,
  input  logic                 rx_pin_i,
  output logic                 gen_data_o,
  output logic                 tx_bit_o,
  output logic                 tx_oe_o
);
  slot_e                pcm_slot;
  logic                 pcm_on, sig_pos, gen_oe, own_en;
  logic [SLOT_BITS-1:0] src, hold_q, cur;

  always_comb begin
    pcm_on   = pcm_a_tx_en_i | pcm_b_tx_en_i;
    pcm_slot = pcm_a_tx_en_i ? SLOT_PCM_A : SLOT_PCM_B;
    sig_pos  = (bit_i < BIT_W'(SIG_BITS));
    src      = '0;
    gen_oe   = 1'b1;
    own_en   = 1'b0;
    case (slot_i)
      SLOT_SIG: begin
        src    = SLOT_BITS'(sig_tx_i);
        gen_oe = sig_pos;
        own_en = sig_tx_en_i & sig_pos;
      end
      SLOT_CTL: begin
        src    = ctl_i;
        gen_oe = ctl_tx_en_i;
        own_en = ctl_tx_en_i;
      end
      default: begin
        src    = (pcm_on && slot_i == pcm_slot) ? pcm_tx_i : '0;
        gen_oe = 1'b1;
        own_en = (slot_i == SLOT_PCM_A) ? pcm_a_tx_en_i : pcm_b_tx_en_i;
      end
    endcase
    // byte is taken live on the first bit, then held
    cur        = first_i ? src : hold_q;
    gen_data_o = cur[bit_i] & gen_oe & ((slot_i != SLOT_SIG) | sig_tx_en_i);
    tx_bit_o   = in2out_i ? rx_pin_i : gen_data_o;
    tx_oe_o    = in2out_i ? own_en : gen_oe;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (first_i) hold_q <= src;
  end

  // R2
  sig_upper_tri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == SLOT_SIG && bit_i >= BIT_W'(SIG_BITS)) |-> !tx_oe_o);

  // R3
  ctl_tri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == SLOT_CTL && !ctl_tx_en_i) |-> !tx_oe_o);

  // R4
  pcm_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in2out_i && (slot_i == SLOT_PCM_A || slot_i == SLOT_PCM_B)) |-> tx_oe_o);
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
  import tdm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  slot_e                slot_i,
  input  logic                 last_i,
  input  logic                 pcm_a_rx_en_i,
  input  logic                 pcm_b_rx_en_i,
  input  logic                 rx_i,
  output logic [SIG_BITS-1:0]  sig_rx_o,
  output logic                 sig_rx_valid_o,
  output logic [SLOT_BITS-1:0] pcm_rx_o,
  output logic                 pcm_rx_valid_o,
  output logic                 ctl_cap_o,
  output logic [SLOT_BITS-1:0] ctl_cap_data_o
);
  logic [SLOT_BITS-2:0] sr_q;
  logic [SLOT_BITS-1:0] byte_w;
  slot_e                rx_slot;
  logic                 rx_on, sig_done, pcm_done;

  always_comb begin
    byte_w         = {sr_q, rx_i};
    rx_on          = pcm_a_rx_en_i | pcm_b_rx_en_i;
    rx_slot        = pcm_a_rx_en_i ? SLOT_PCM_A : SLOT_PCM_B;
    sig_done       = last_i && slot_i == SLOT_SIG;
    pcm_done       = last_i && rx_on && slot_i == rx_slot;
    ctl_cap_o      = last_i && slot_i == SLOT_CTL;
    ctl_cap_data_o = byte_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q           <= '0;
      sig_rx_o       <= '0;
      sig_rx_valid_o <= 1'b0;
      pcm_rx_o       <= '0;
      pcm_rx_valid_o <= 1'b0;
    end else begin
      sr_q           <= byte_w[SLOT_BITS-2:0];
      sig_rx_valid_o <= sig_done;
      pcm_rx_valid_o <= pcm_done;
      if (sig_done) sig_rx_o <= byte_w[SIG_BITS-1:0];
      if (pcm_done) pcm_rx_o <= byte_w;
    end
  end

  // R5
  pcm_valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_rx_valid_o |=> !pcm_rx_valid_o);

  // R5
  pcm_valid_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_rx_valid_o |-> $past(rx_on));

  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sig_rx_valid_o, pcm_rx_valid_o}));
endmodule

// File: rtl/tdm_port_ctrl.sv
module tdm_port_ctrl
  import tdm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_start_i,
  input  logic                 rx_bit_i,
  output logic                 tx_bit_o,
  output logic                 tx_oe_o,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [SLOT_BITS-1:0] reg_wdata_i,
  output logic [SLOT_BITS-1:0] reg_rdata_o,
  input  logic [SIG_BITS-1:0]  sig_tx_i,
  output logic [SIG_BITS-1:0]  sig_rx_o,
  output logic                 sig_rx_valid_o,
  input  logic [SLOT_BITS-1:0] pcm_tx_i,
  output logic [SLOT_BITS-1:0] pcm_rx_o,
  output logic                 pcm_rx_valid_o
);
  slot_e                slot;
  logic [BIT_W-1:0]     bit_pos;
  logic                 first, last;
  logic [SLOT_BITS-1:0] ctl, ctl_cap_data;
  logic [EN_W-1:0]      en;
  logic [LB_W-1:0]      lb;
  logic                 ctl_cap, gen_data, rx_eff;

  tdm_slot_counter u_cnt (
    .clk_i, .rst_ni, .frame_start_i,
    .slot_o(slot), .bit_o(bit_pos), .first_o(first), .last_o(last)
  );

  tdm_regfile u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ctl_cap_i(ctl_cap), .ctl_cap_data_i(ctl_cap_data),
    .ctl_o(ctl), .en_o(en), .lb_o(lb)
  );

  tdm_tx_path u_tx (
    .clk_i, .rst_ni,
    .slot_i(slot), .bit_i(bit_pos), .first_i(first),
    .sig_tx_en_i(en[EN_SIG_TX]), .ctl_tx_en_i(en[EN_CTL_TX]),
    .pcm_a_tx_en_i(en[EN_PCMA_TX]), .pcm_b_tx_en_i(en[EN_PCMB_TX]),
    .in2out_i(lb[LB_IN2OUT]), .ctl_i(ctl), .sig_tx_i, .pcm_tx_i,
    .rx_pin_i(rx_bit_i), .gen_data_o(gen_data), .tx_bit_o, .tx_oe_o
  );

  // out-to-in loopback taps the generated stream, never the pin mux
  assign rx_eff = lb[LB_OUT2IN] ? gen_data : rx_bit_i;

  tdm_rx_path u_rx (
    .clk_i, .rst_ni,
    .slot_i(slot), .last_i(last),
    .pcm_a_rx_en_i(en[EN_PCMA_RX]), .pcm_b_rx_en_i(en[EN_PCMB_RX]),
    .rx_i(rx_eff),
    .sig_rx_o, .sig_rx_valid_o, .pcm_rx_o, .pcm_rx_valid_o,
    .ctl_cap_o(ctl_cap), .ctl_cap_data_o(ctl_cap_data)
  );

  // R8
  in2out_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb[LB_IN2OUT] |-> (tx_bit_o == rx_bit_i));
endmodule

// File: tb/tdm_port_ctrl_tb.sv
module tdm_port_ctrl_tb;
  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       frame_start_i = 0;
  logic       rx_bit_i = 0;
  logic       tx_bit_o, tx_oe_o;
  logic       reg_we_i = 0;
  logic [1:0] reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic [1:0] sig_tx_i = 0;
  logic [1:0] sig_rx_o;
  logic       sig_rx_valid_o;
  logic [7:0] pcm_tx_i = 0;
  logic [7:0] pcm_rx_o;
  logic       pcm_rx_valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [5:0]  g_en;
  logic [1:0]  g_lb, g_sig;
  logic [7:0]  g_ctl, g_pcm;
  logic [31:0] g_rxw;
  logic [7:0]  effb [4];

  always #4 clk_i = ~clk_i;

  tdm_port_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  function automatic int tx_sel();
    return g_en[2] ? 2 : (g_en[3] ? 3 : 0);
  endfunction

  function automatic int rx_sel();
    return g_en[4] ? 2 : (g_en[5] ? 3 : 0);
  endfunction

  // {oe, data} of the generated stream
  function automatic logic [1:0] gen_bit(input int s, input int b);
    logic oe, d;
    case (s)
      0: begin oe = (b < 2); d = oe & g_en[0] & (b < 2 ? g_sig[b[0]] : 1'b0); end
      1: begin oe = g_en[1]; d = g_en[1] & g_ctl[b]; end
      default: begin oe = 1; d = (tx_sel() == s) & g_pcm[b]; end
    endcase
    return {oe, d};
  endfunction

  function automatic logic own_en(input int s, input int b);
    case (s)
      0: return g_en[0] & (b < 2);
      1: return g_en[1];
      2: return g_en[2];
      default: return g_en[3];
    endcase
  endfunction

  task automatic run_frame();
    string tag;
    wr(2'd0, g_ctl);
    wr(2'd1, {2'b00, g_en});
    wr(2'd2, {6'b0, g_lb});
    sig_tx_i = g_sig;
    pcm_tx_i = g_pcm;
    for (int k = 0; k < 32; k++) begin
      int s, b;
      logic [1:0] g;
      logic exp_oe, exp_d;
      s = k / 8; b = 7 - (k % 8);
      frame_start_i = (k == 0);
      rx_bit_i = g_rxw[31-k];
      #1;
      g = gen_bit(s, b);
      exp_oe = g_lb[0] ? own_en(s, b) : g[1];
      exp_d  = g_lb[0] ? rx_bit_i : g[0];
      effb[s][b] = g_lb[1] ? g[0] : rx_bit_i;
      tag = g_lb[0] ? "R8 loop in-out" : (s == 0 ? "R1/R2 slot0" : (s == 1 ? "R1/R3 slot1" : "R1/R4 voice"));
      chk(tx_oe_o == exp_oe && (!exp_oe || tx_bit_o == exp_d), tag, {tx_oe_o, tx_bit_o}, {exp_oe, exp_d});
      if (k > 0) begin
        chk(sig_rx_valid_o == (k == 8), "R6 sig strobe", sig_rx_valid_o, (k == 8));
        chk(pcm_rx_valid_o == (k == 24 && rx_sel() == 2), "R5 pcm strobe", pcm_rx_valid_o, (k == 24 && rx_sel() == 2));
        if (k == 8)
          chk(sig_rx_o == effb[0][1:0], g_lb[1] ? "R9 sig loop" : "R6 sig data", sig_rx_o, effb[0][1:0]);
        if (k == 24 && rx_sel() == 2)
          chk(pcm_rx_o == effb[2], g_lb[1] ? "R9 pcm loop" : "R5 pcm slot2", pcm_rx_o, effb[2]);
      end
      @(negedge clk_i);
    end
    frame_start_i = 0;
    reg_addr_i = 2'd0;
    #1;
    chk(pcm_rx_valid_o == (rx_sel() == 3), "R5 pcm strobe end", pcm_rx_valid_o, (rx_sel() == 3));
    if (rx_sel() == 3)
      chk(pcm_rx_o == effb[3], g_lb[1] ? "R9 pcm loop" : "R5 pcm slot3", pcm_rx_o, effb[3]);
    chk(reg_rdata_o == effb[1], g_lb[1] ? "R9 ctl capture" : "R7 ctl capture", reg_rdata_o, effb[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    // R11 reset state
    chk(tx_oe_o == 0, "R11 oe in reset", tx_oe_o, 0);
    chk(sig_rx_valid_o == 0 && pcm_rx_valid_o == 0, "R11 strobes", {sig_rx_valid_o, pcm_rx_valid_o}, 0);
    @(negedge clk_i);
    rst_ni = 1;
    for (int a = 0; a < 3; a++) begin
      reg_addr_i = a[1:0];
      #1;
      chk(reg_rdata_o == 0, "R11 reg reset", reg_rdata_o, 0);
    end
    @(negedge clk_i);

    // R10 reserved bits and address
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    reg_addr_i = 2'd1; #1;
    chk(reg_rdata_o == 8'h3F, "R10 en rsvd", reg_rdata_o, 8'h3F);
    reg_addr_i = 2'd2; #1;
    chk(reg_rdata_o == 8'h03, "R10 lb rsvd", reg_rdata_o, 8'h03);
    reg_addr_i = 2'd3; #1;
    chk(reg_rdata_o == 8'h00, "R10 addr3", reg_rdata_o, 8'h00);
    @(negedge clk_i);

    // R7 capture beats same-cycle write
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h11);
    for (int k = 0; k < 32; k++) begin
      frame_start_i = (k == 0);
      rx_bit_i = 32'h00C3_0000 >> (31 - k);
      if (k == 15) begin reg_we_i = 1; reg_addr_i = 2'd0; reg_wdata_i = 8'h5A; end
      if (k == 16) reg_we_i = 0;
      @(negedge clk_i);
    end
    frame_start_i = 0;
    reg_addr_i = 2'd0; #1;
    chk(reg_rdata_o == 8'hC3, "R7 capture priority", reg_rdata_o, 8'hC3);

    // sweep all enable and loopback settings
    for (int i = 0; i < 256; i++) begin
      g_en  = i[5:0];
      g_lb  = i[7:6];
      g_ctl = 8'(i * 29 + 3);
      g_pcm = 8'(i * 53 + 17);
      g_sig = i[1:0] ^ 2'b01;
      g_rxw = 32'(i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
      run_frame();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule